// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block keeps the base mode settings of a low-power double-data-rate memory and turns each burst request into a stream of column addresses. A load-mode input, qualified by the bank-select bits, delivers a new setting word. The word is decoded into a burst length, a burst ordering and a read latency. An illegal word is refused: the stored settings stay as they were and an error pulse is raised.

A start request carries the first column of a burst. From the next cycle the block issues one column address per cycle, for as many cycles as the burst length. Only the low bits inside an aligned block of burst-length columns change, so the addresses wrap at the block edge. They advance by counting in sequential mode and by XOR with the beat index in interleaved mode. A last flag marks the final beat, and busy covers every beat. Reads and writes share the same sequence. A memory model or a controller can use the block to drive its column counter.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the stored settings are burst length 2, sequential order and latency 3. Busy, col_valid, col_last, mode_err and start_err are all low.
- R2: A load with bank bits 00 and legal codes updates the settings one cycle later. Length code addr[2:0] maps 001 to 2, 010 to 4, 011 to 8 and 100 to 16, shown on burst_len as that number.
- R3: addr[3] selects the order: 0 gives sequential (burst_ilv=0) and 1 gives interleaved (burst_ilv=1).
- R4: Latency code addr[6:4] maps 010 to 2 and 011 to 3, shown on cas_lat as that number.
- R5: A load with bank bits 00 is refused if the length code is 000, 101, 110 or 111, if the latency code is anything other than 010 or 011, or if any address bit above bit 6 is 1. A refused load raises mode_err for exactly one cycle, in the cycle after the load, and leaves all settings unchanged.
- R6: A load with nonzero bank bits changes no setting and raises no mode_err.
- R7: A start accepted while idle makes col_valid and busy high from the next cycle for exactly burst-length cycles. The first beat presents start_col itself.
- R8: In sequential order, beat i carries low bits (s + i) mod BL, where s is the low log2(BL) bits of start_col.
- R9: In interleaved order, beat i carries low bits s XOR i.
- R10: Column bits above the low log2(BL) bits equal those of start_col on every beat.
- R11: col_last is high on the final beat of a burst and on no other cycle.
- R12: A start raised while busy is high is ignored: the running burst continues unchanged and start_err pulses for one cycle in the next cycle.
- R13: A load during a burst does not alter the length or order of that burst. The new settings apply from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | Load-mode command strobe |
| mode_ba | input | BA_W | Bank-select bits of the load |
| mode_addr | input | ADDR_W | Address bus carrying the setting word |
| start | input | 1 | Burst request |
| start_col | input | COL_W | First column of the burst |
| burst_len | output | 5 | Stored burst length (2, 4, 8 or 16) |
| burst_ilv | output | 1 | Stored order, 1 = interleaved |
| cas_lat | output | 2 | Stored read latency (2 or 3) |
| mode_err | output | 1 | One-cycle pulse for a refused load |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Current beat is the final one |
| busy | output | 1 | A burst is in progress |
| start_err | output | 1 | One-cycle pulse for an ignored start |

## Verification
The bench aims starts at the top of the aligned block, where a sequencer that carries out of the low field would change the block bits and leave the block. It sends interleaved bursts of length 16 from odd starting columns, which break a design that adds instead of XORing. It covers every reserved length and latency code and stray upper address bits; a weak decoder would accept these and corrupt the settings. It also raises start and load in the middle of a burst, which catches a design that restarts the burst or picks up the new length before the burst ends.

// File: rtl/bcs_pkg.sv
// Shared constants and the stored-settings record of the burst column sequencer.
// Assumes a largest burst of 16 beats.
package bcs_pkg;
    localparam int BL_LOG_MAX = 4;               // log2 of the largest burst
    localparam int CNT_W      = BL_LOG_MAX;      // beat index width
    localparam int LEN_W      = BL_LOG_MAX + 1;  // width of a burst length value

    typedef struct packed {
        logic [2:0] bl_log;   // log2 of burst length, 1..4
        logic       ilv;      // 1 = interleaved order
        logic [1:0] cl;       // latency, 2 or 3
    } mode_t;

    localparam mode_t MODE_RESET = '{bl_log: 3'd1, ilv: 1'b0, cl: 2'd3};
endpackage

// File: rtl/bcs_mode_reg.sv
// Decodes and stores the base mode word. A load is taken only when the bank bits
// are all zero. An illegal word is refused with a one-cycle error pulse.
// Assumes ADDR_W > 7.
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output mode_t             mode,
    output logic              err
);
    localparam int UPPER_LSB = 7;

    logic  bl_ok;
    logic  cl_ok;
    logic  upper_ok;
    logic  base_sel;
    mode_t decoded;

    // Check each field of the incoming word for a legal code.
    always_comb begin
        bl_ok    = (addr[2:0] >= 3'd1) && (addr[2:0] <= 3'd4);
        cl_ok    = (addr[6:4] == 3'b010) || (addr[6:4] == 3'b011);
        upper_ok = (addr[ADDR_W-1:UPPER_LSB] == '0);
        base_sel = (ba == '0);
        decoded.bl_log = addr[2:0];
        decoded.ilv    = addr[3];
        decoded.cl     = addr[5:4];
    end

    // Store legal words and flag refused ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_RESET;
            err  <= 1'b0;
        end else begin
            err <= 1'b0;
            if (load && base_sel) begin
                if (bl_ok && cl_ok && upper_ok) begin
                    mode <= decoded;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end

    p_refused_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (mode == $past(mode)));
    p_cl_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.cl == 2'd2) || (mode.cl == 2'd3));
    p_bl_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.bl_log >= 3'd1) && (mode.bl_log <= 3'd4));
    p_other_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (ba != '0)) |=> (!err && mode == $past(mode)));
endmodule

// File: rtl/bcs_addr_gen.sv
// Produces one column per beat for an accepted burst. Only the low log2(BL)
// bits move: sequential order counts, interleaved order XORs the beat index.
// The length and order are latched at start, so a later load cannot alter a running burst.
// Assumes a start is only presented while no burst runs, and COL_W > CNT_W.
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [COL_W-1:0] go_col,
    input  logic [2:0]       go_log,
    input  logic             go_ilv,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last
);
    logic [COL_W-1:0] base_q;
    logic [CNT_W-1:0] idx_q;
    logic [2:0]       log_q;
    logic             ilv_q;
    logic             valid_q;
    logic [CNT_W-1:0] low_mask;
    logic [CNT_W-1:0] seq_low;
    logic [CNT_W-1:0] ilv_low;
    logic [CNT_W-1:0] mov_low;

    // Mark the low bits that belong to the burst block.
    always_comb begin
        for (int b = 0; b < CNT_W; b++) begin
            low_mask[b] = (b < int'(log_q));
        end
    end

    // Form the beat address from the latched start column and the beat index.
    always_comb begin
        seq_low  = base_q[CNT_W-1:0] + idx_q;
        ilv_low  = base_q[CNT_W-1:0] ^ idx_q;
        mov_low  = ilv_q ? ilv_low : seq_low;
        col_out  = {base_q[COL_W-1:CNT_W],
                    (base_q[CNT_W-1:0] & ~low_mask) | (mov_low & low_mask)};
        col_valid = valid_q;
        col_last  = valid_q && (idx_q == low_mask);
    end

    // Advance the beat index, and stop after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            idx_q   <= '0;
            log_q   <= 3'd1;
            ilv_q   <= 1'b0;
            valid_q <= 1'b0;
        end else if (go) begin
            base_q  <= go_col;
            idx_q   <= '0;
            log_q   <= go_log;
            ilv_q   <= go_ilv;
            valid_q <= 1'b1;
        end else if (valid_q) begin
            if (col_last) begin
                valid_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    p_last_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !go) |=> !col_valid);
    p_upper_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid)) |->
            (col_out[COL_W-1:CNT_W] == $past(col_out[COL_W-1:CNT_W])));
    p_first_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (col_valid && col_out == $past(go_col)));
endmodule

// File: rtl/burst_col_seq.sv
// Top of the burst column sequencer: the mode register, the start gate and the
// address generator. A start is accepted only when no burst runs; otherwise it
// is dropped and start_err pulses once. Busy covers every beat of a burst.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [BA_W-1:0]   mode_ba,
    input  logic [ADDR_W-1:0] mode_addr,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    output logic [LEN_W-1:0]  burst_len,
    output logic              burst_ilv,
    output logic [1:0]        cas_lat,
    output logic              mode_err,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic              busy,
    output logic              start_err
);
    mode_t mode;
    logic  accept;
    logic  running;

    bcs_mode_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
        .clk  (clk),
        .rst_n(rst_n),
        .load (mode_load),
        .ba   (mode_ba),
        .addr (mode_addr),
        .mode (mode),
        .err  (mode_err)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (accept),
        .go_col   (start_col),
        .go_log   (mode.bl_log),
        .go_ilv   (mode.ilv),
        .col_out  (col_out),
        .col_valid(running),
        .col_last (col_last)
    );

    // Gate the start request and present the stored settings.
    always_comb begin
        accept    = start && !running;
        col_valid = running;
        busy      = running;
        burst_len = LEN_W'(1) << mode.bl_log;
        burst_ilv = mode.ilv;
        cas_lat   = mode.cl;
    end

    // Flag a start that arrived during a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_err <= 1'b0;
        end else begin
            start_err <= start && running;
        end
    end

    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> start_err);
    p_last_in_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> busy);
    p_busy_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !col_last) |=> busy);
endmodule

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
    localparam int COL_W  = 10;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_load = 1'b0;
    logic [BA_W-1:0]   mode_ba = '0;
    logic [ADDR_W-1:0] mode_addr = '0;
    logic              start = 1'b0;
    logic [COL_W-1:0]  start_col = '0;
    logic [4:0]        burst_len;
    logic              burst_ilv;
    logic [1:0]        cas_lat;
    logic              mode_err;
    logic [COL_W-1:0]  col_out;
    logic              col_valid;
    logic              col_last;
    logic              busy;
    logic              start_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model of the stored settings
    int m_len = 2;
    int m_ilv = 0;
    int m_cl  = 3;

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .ADDR_W(ADDR_W), .BA_W(BA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_ba(mode_ba),
        .mode_addr(mode_addr), .start(start), .start_col(start_col),
        .burst_len(burst_len), .burst_ilv(burst_ilv), .cas_lat(cas_lat),
        .mode_err(mode_err), .col_out(col_out), .col_valid(col_valid),
        .col_last(col_last), .busy(busy), .start_err(start_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic bit word_legal(input logic [ADDR_W-1:0] a);
        return (a[2:0] >= 1 && a[2:0] <= 4) && (a[6:4] == 3'b010 || a[6:4] == 3'b011)
               && (a[ADDR_W-1:7] == '0);
    endfunction

    // Update the model; return the expected error pulse.
    function automatic int model_load(input logic [BA_W-1:0] ba, input logic [ADDR_W-1:0] a);
        if (ba != '0) return 0;
        if (!word_legal(a)) return 1;
        m_len = 1 << a[2:0];
        m_ilv = a[3];
        m_cl  = a[6:4];
        return 0;
    endfunction

    function automatic int exp_col(input int base, input int i, input int len, input int ilv);
        int msk = len - 1;
        int low = ilv ? (base ^ i) : (base + i);
        return (base & ~msk) | (low & msk);
    endfunction

    function automatic logic [ADDR_W-1:0] legal_word(input int blc, input int ilv, input int clc);
        logic [ADDR_W-1:0] a = '0;
        a[2:0] = blc[2:0];
        a[3]   = ilv[0];
        a[6:4] = clc[2:0];
        return a;
    endfunction

    task automatic check_mode(input string req);
        chk({req, " burst_len"}, burst_len, m_len);
        chk({req, " burst_ilv"}, burst_ilv, m_ilv);
        chk({req, " cas_lat"}, cas_lat, m_cl);
    endtask

    task automatic do_load(input logic [BA_W-1:0] ba, input logic [ADDR_W-1:0] a);
        int e;
        string req;
        @(negedge clk);
        mode_load = 1'b1; mode_ba = ba; mode_addr = a;
        @(negedge clk);
        mode_load = 1'b0; mode_ba = '0;
        e = model_load(ba, a);
        req = (ba != '0) ? "R6" : (e != 0 ? "R5" : "R2/R3/R4");
        chk({req, " mode_err"}, mode_err, e);
        check_mode(req);
        if (e != 0) begin
            @(negedge clk);
            chk("R5 mode_err single pulse", mode_err, 0);
        end
    endtask

    // Run one burst; optionally raise start or a legal load during beat inj_s / inj_l.
    task automatic run_burst(input int col, input int inj_s, input int inj_l,
                             input logic [ADDR_W-1:0] new_word);
        int len = m_len;
        int ilv = m_ilv;
        int hit_s = 0;
        int hit_l = 0;
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(col);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            start = 1'b0; mode_load = 1'b0;
            start_col = COL_W'($urandom);
            if (hit_s) begin
                chk("R12 start_err", start_err, 1);
                hit_s = 0;
            end else begin
                chk("R12 start_err idle", start_err, 0);
            end
            if (hit_l) begin
                chk("R13 load err", mode_err, model_load('0, new_word));
                hit_l = 0;
            end
            chk(ilv ? "R9 interleaved col" : "R8 sequential col", col_out, exp_col(col, i, len, ilv));
            chk("R10 upper bits", col_out / len, col / len);
            chk("R7 col_valid", col_valid, 1);
            chk("R7 busy", busy, 1);
            chk("R11 col_last", col_last, (i == len - 1) ? 1 : 0);
            if (i == inj_s) begin start = 1'b1; hit_s = 1; end
            if (i == inj_l) begin mode_load = 1'b1; mode_addr = new_word; hit_l = 1; end
        end
        @(negedge clk);
        start = 1'b0; mode_load = 1'b0;
        if (hit_s) chk("R12 start on last beat", start_err, 1);
        if (hit_l) chk("R13 load err", mode_err, model_load('0, new_word));
        chk("R7 busy ends", busy, 0);
        chk("R11 col_last ends", col_last, 0);
        check_mode("R13");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 burst_len", burst_len, 2);
        chk("R1 burst_ilv", burst_ilv, 0);
        chk("R1 cas_lat", cas_lat, 3);
        chk("R1 busy", busy, 0);
        chk("R1 col_valid", col_valid, 0);
        chk("R1 col_last", col_last, 0);
        chk("R1 mode_err", mode_err, 0);
        chk("R1 start_err", start_err, 0);

        // burst from reset settings, wrapping at the block end
        run_burst(10'h3FF, -1, -1, '0);

        // every legal length in both orders, starts at each block edge
        for (int blc = 1; blc <= 4; blc++) begin
            for (int o = 0; o < 2; o++) begin
                do_load('0, legal_word(blc, o, 2 + o));
                run_burst(((1 << blc) - 1) | 10'h2A0, -1, -1, '0);
                run_burst(10'h155, -1, -1, '0);
            end
        end

        // interleaved 16 from odd starts
        do_load('0, legal_word(4, 1, 3));
        run_burst(10'h0B7, -1, -1, '0);
        run_burst(10'h3F1, -1, -1, '0);

        // R5 reserved length codes, latency codes, stray upper bits
        for (int c = 0; c < 8; c++) begin
            if (c >= 1 && c <= 4) continue;
            do_load('0, legal_word(c, 0, 2));
        end
        for (int c = 0; c < 8; c++) begin
            if (c == 2 || c == 3) continue;
            do_load('0, legal_word(3, 1, c));
        end
        for (int b = 7; b < ADDR_W; b++) begin
            logic [ADDR_W-1:0] w = legal_word(2, 1, 2);
            w[b] = 1'b1;
            do_load('0, w);
        end
        // R6 other banks
        do_load(2'b01, legal_word(4, 1, 2));
        do_load(2'b10, legal_word(1, 0, 3));
        do_load(2'b11, 13'h1FFF);

        // R12 and R13 directed
        do_load('0, legal_word(3, 0, 3));
        run_burst(10'h1FE, 2, -1, '0);
        run_burst(10'h0C3, -1, 1, legal_word(4, 1, 2));
        run_burst(10'h0C3, 6, 9, legal_word(1, 0, 3));
        run_burst(10'h22F, 0, -1, '0);

        // constrained random
        for (int k = 0; k < 300; k++) begin
            logic [ADDR_W-1:0] w;
            logic [BA_W-1:0] ba;
            int len;
            if ($urandom % 4 == 0) begin
                w = ADDR_W'($urandom);
                if ($urandom % 2 == 0) w[ADDR_W-1:7] = '0;
            end else begin
                w = legal_word(1 + $urandom % 4, $urandom % 2, 2 + $urandom % 2);
            end
            ba = ($urandom % 5 == 0) ? BA_W'($urandom) : '0;
            do_load(ba, w);
            len = m_len;
            run_burst(int'($urandom % 1024),
                      ($urandom % 3 == 0) ? int'($urandom % len) : -1,
                      ($urandom % 3 == 0) ? int'($urandom % len) : -1,
                      legal_word(1 + $urandom % 4, $urandom % 2, 2 + $urandom % 2));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule